// File: doc/BRIEF.md
# Pointer-Indirect Byte Load Unit

This block carries out an indirect byte load in which the address comes from a 16-bit pointer kept in a pair of general registers. A request names the pointer pair, an addressing mode and a destination register. The unit works out the effective address and reads one byte from the data space. It writes the byte into the destination register and, when the mode calls for it, writes the adjusted pointer back into its pair. No status flags are involved.

The data space is one flat 16-bit map with three regions. The lowest 32 addresses alias the unit's own register file. The next 64 addresses go to a synchronous I/O read port. Everything above that goes to a synchronous SRAM byte port. Both external ports return data in the cycle after the strobe. The register file is part of the block. It has a host port so that the surrounding core can write and read registers while no load is running.

Top module: `ptrld_unit`

## Requirements
- R1: Pointer select 0 uses registers 27 (high byte) and 26 (low byte). Select 1 uses 29:28 and select 2 uses 31:30.
- R2: In mode 0 (plain) the effective address equals the pointer and the pointer pair is not modified.
- R3: In mode 1 (post-increment) the effective address equals the pointer. The pointer pair then holds pointer+1 modulo 65536, so 0xFFFF becomes 0x0000.
- R4: In mode 2 (pre-decrement) the effective address is pointer-1 modulo 65536, and that value is written back to the pair, so 0x0000 becomes 0xFFFF.
- R5: Address decode and strobes:
  - An effective address below 0x20 loads the register-file byte at that index, taken as it stood while the access was issued.
  - An address from 0x20 to 0x5F raises `io_re` with `io_addr` = address-0x20.
  - An address of 0x60 or above raises `mem_re` with `mem_addr` = address.
  - A strobe is high only in the first busy cycle, and never both at once.
- R6: An accepted request keeps `busy` high for exactly two cycles. In the cycle after that, `done` is high for one cycle, and by then the destination register already holds the loaded byte.
- R7: When the destination register is one of the bytes of the pointer pair being updated, the loaded byte overrides the pointer write-back for that byte.
- R8: A request is ignored while `busy` is high, when the select is 3, or when the mode is 3. No strobe, no busy and no register change follow.
- R9: Host writes take effect only while the unit is idle; a host write presented while busy has no effect. `host_rdata` shows register `host_ridx` combinationally.
- R10: After reset all registers read 0, and `busy`, `done`, `io_re` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request |
| ptr_sel | input | 2 | Pointer pair select (0,1,2; 3 rejected) |
| mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 rejected |
| dst_idx | input | 5 | Destination register index |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host register write enable |
| host_widx | input | 5 | Host write index |
| host_wdata | input | 8 | Host write data |
| host_ridx | input | 5 | Host read index |
| host_rdata | output | 8 | Host read data |
| io_re | output | 1 | I/O read strobe |
| io_addr | output | 6 | I/O offset |
| io_rdata | input | 8 | I/O read data, valid the cycle after the strobe |
| mem_re | output | 1 | SRAM read strobe |
| mem_addr | output | 16 | SRAM byte address |
| mem_rdata | input | 8 | SRAM read data, valid the cycle after the strobe |

## Verification
The hardest case to reach is a load whose address falls in the register alias region while that same region holds the pointer or the destination. In that case an old register value, a pointer write-back and a destination write all fall within two cycles. Random pointers over a full 16-bit range almost never land there. The stimulus therefore biases pointer values toward the alias range, the I/O window and the region edges, and adds directed loads that target a pointer's own bytes and wrap at 0x0000 and 0xFFFF.

// File: rtl/ptrld_pkg.sv
package ptrld_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned REG_COUNT = 32;
  localparam int unsigned IO_START  = 32;
  localparam int unsigned MEM_START = 96;
  localparam int unsigned PAIR_BASE = 26;

  typedef enum logic [1:0] {AM_PLAIN = 2'd0, AM_POSTINC = 2'd1, AM_PREDEC = 2'd2, AM_BAD = 2'd3} amode_e;
  typedef enum logic [1:0] {RG_REG = 2'd0, RG_IO = 2'd1, RG_MEM = 2'd2} region_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACC = 2'd1, ST_WB = 2'd2} state_e;

  function automatic logic [ADDR_W-1:0] f_eff_addr(input logic [ADDR_W-1:0] p, input amode_e m);
    return (m == AM_PREDEC) ? p - ADDR_W'(1) : p;
  endfunction

  function automatic logic [ADDR_W-1:0] f_ptr_next(input logic [ADDR_W-1:0] p, input amode_e m);
    case (m)
      AM_POSTINC: return p + ADDR_W'(1);
      AM_PREDEC:  return p - ADDR_W'(1);
      default:    return p;
    endcase
  endfunction

  function automatic region_e f_region(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(IO_START))       return RG_REG;
    else if (a < ADDR_W'(MEM_START)) return RG_IO;
    else                             return RG_MEM;
  endfunction
endpackage

// File: rtl/ptrld_regfile.sv
module ptrld_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [IW-1:0]   host_widx,
  input  logic [DW-1:0]   host_wdata,
  input  logic            ptr_we,
  input  logic [IW-1:0]   ptr_lo_idx,
  input  logic [2*DW-1:0] ptr_wval,
  input  logic            dst_we,
  input  logic [IW-1:0]   dst_idx,
  input  logic [DW-1:0]   dst_wdata,
  input  logic [IW-1:0]   host_ridx,
  output logic [DW-1:0]   host_rdata,
  output logic [2*DW-1:0] ptr_cur,
  input  logic [IW-1:0]   alias_idx,
  output logic [DW-1:0]   alias_data
);
  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] ptr_hi_idx;

  assign ptr_hi_idx = ptr_lo_idx + IW'(1);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_dst, hit_lo, hit_hi, hit_host;
    assign hit_dst  = dst_we  && (dst_idx == IW'(g));
    assign hit_lo   = ptr_we  && (ptr_lo_idx == IW'(g));
    assign hit_hi   = ptr_we  && (ptr_hi_idx == IW'(g));
    assign hit_host = host_we && (host_widx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)        regs[g] <= '0;
      else if (hit_dst)  regs[g] <= dst_wdata;
      else if (hit_lo)   regs[g] <= ptr_wval[DW-1:0];
      else if (hit_hi)   regs[g] <= ptr_wval[2*DW-1:DW];
      else if (hit_host) regs[g] <= host_wdata;
    end
  end

  assign host_rdata = regs[host_ridx];
  assign ptr_cur    = {regs[ptr_hi_idx], regs[ptr_lo_idx]};
  assign alias_data = regs[alias_idx];
endmodule

// File: rtl/ptrld_agu.sv
module ptrld_agu
  import ptrld_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned IO_BASE  = 32,
  parameter int unsigned MEM_BASE = 96,
  parameter int unsigned NREG   = 32,
  localparam int unsigned IW    = $clog2(NREG),
  localparam int unsigned IOW   = $clog2(MEM_BASE - IO_BASE)
) (
  input  logic            active,
  input  amode_e          mode,
  input  logic [AW-1:0]   ptr_cur,
  output logic [AW-1:0]   ptr_next,
  output region_e         region,
  output logic            io_re,
  output logic [IOW-1:0]  io_addr,
  output logic            mem_re,
  output logic [AW-1:0]   mem_addr,
  output logic [IW-1:0]   alias_idx
);
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] io_off;

  assign eff_addr  = f_eff_addr(ptr_cur, mode);
  assign ptr_next  = f_ptr_next(ptr_cur, mode);
  assign region    = f_region(eff_addr);
  assign io_off    = eff_addr - AW'(IO_BASE);
  assign io_addr   = io_off[IOW-1:0];
  assign mem_addr  = eff_addr;
  assign alias_idx = eff_addr[IW-1:0];
  assign io_re     = active && (region == RG_IO);
  assign mem_re    = active && (region == RG_MEM);
endmodule

// File: rtl/ptrld_ctrl.sv
module ptrld_ctrl
  import ptrld_pkg::*;
#(
  parameter int unsigned NREG     = 32,
  parameter int unsigned PTR_BASE = 26,
  localparam int unsigned IW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    ptr_sel,
  input  logic [1:0]    mode,
  input  logic [IW-1:0] dst_idx,
  output logic          busy,
  output logic          in_acc,
  output logic          in_wb,
  output logic          load_go,
  output logic          done,
  output amode_e        lat_mode,
  output logic [IW-1:0] lat_dst,
  output logic [IW-1:0] ptr_lo_idx
);
  state_e      state_q;
  logic [1:0]  sel_q;

  assign load_go = start && (state_q == ST_IDLE) && (ptr_sel != 2'd3) && (mode != 2'(AM_BAD));
  assign in_acc  = (state_q == ST_ACC);
  assign in_wb   = (state_q == ST_WB);
  assign busy    = in_acc || in_wb;
  assign ptr_lo_idx = IW'(PTR_BASE) + IW'({sel_q, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      lat_mode <= AM_PLAIN;
      lat_dst  <= '0;
      done     <= 1'b0;
    end else begin
      done <= in_wb;
      case (state_q)
        ST_IDLE: if (load_go) begin
          state_q  <= ST_ACC;
          sel_q    <= ptr_sel;
          lat_mode <= amode_e'(mode);
          lat_dst  <= dst_idx;
        end
        ST_ACC:  state_q <= ST_WB;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> busy ##1 busy ##1 (done && !busy)); // R6
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && start) |=> in_wb); // R8
endmodule

// File: rtl/ptrld_unit.sv
module ptrld_unit
  import ptrld_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned NREG     = REG_COUNT,
  parameter int unsigned IO_BASE  = IO_START,
  parameter int unsigned MEM_BASE = MEM_START,
  parameter int unsigned PTR_BASE = PAIR_BASE,
  localparam int unsigned IW      = $clog2(NREG),
  localparam int unsigned IOW     = $clog2(MEM_BASE - IO_BASE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     ptr_sel,
  input  logic [1:0]     mode,
  input  logic [IW-1:0]  dst_idx,
  output logic           busy,
  output logic           done,
  input  logic           host_we,
  input  logic [IW-1:0]  host_widx,
  input  logic [DW-1:0]  host_wdata,
  input  logic [IW-1:0]  host_ridx,
  output logic [DW-1:0]  host_rdata,
  output logic           io_re,
  output logic [IOW-1:0] io_addr,
  input  logic [DW-1:0]  io_rdata,
  output logic           mem_re,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata
);
  logic          in_acc, in_wb, load_go;
  amode_e        lat_mode;
  logic [IW-1:0] lat_dst, ptr_lo_idx, alias_idx;
  logic [AW-1:0] ptr_cur, ptr_next;
  logic [DW-1:0] alias_data, alias_q, ld_byte;
  region_e       region, region_q;
  logic          ptr_we;

  ptrld_ctrl #(.NREG(NREG), .PTR_BASE(PTR_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_sel(ptr_sel), .mode(mode),
    .dst_idx(dst_idx), .busy(busy), .in_acc(in_acc), .in_wb(in_wb),
    .load_go(load_go), .done(done), .lat_mode(lat_mode), .lat_dst(lat_dst),
    .ptr_lo_idx(ptr_lo_idx)
  );

  ptrld_agu #(.AW(AW), .IO_BASE(IO_BASE), .MEM_BASE(MEM_BASE), .NREG(NREG)) u_agu (
    .active(in_acc), .mode(lat_mode), .ptr_cur(ptr_cur), .ptr_next(ptr_next),
    .region(region), .io_re(io_re), .io_addr(io_addr), .mem_re(mem_re),
    .mem_addr(mem_addr), .alias_idx(alias_idx)
  );

  assign ptr_we = in_acc && (lat_mode != AM_PLAIN);

  ptrld_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we && !busy), .host_widx(host_widx), .host_wdata(host_wdata),
    .ptr_we(ptr_we), .ptr_lo_idx(ptr_lo_idx), .ptr_wval(ptr_next),
    .dst_we(in_wb), .dst_idx(lat_dst), .dst_wdata(ld_byte),
    .host_ridx(host_ridx), .host_rdata(host_rdata),
    .ptr_cur(ptr_cur), .alias_idx(alias_idx), .alias_data(alias_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region_q <= RG_REG;
      alias_q  <= '0;
    end else if (in_acc) begin
      region_q <= region;
      alias_q  <= alias_data;
    end
  end

  always_comb begin
    case (region_q)
      RG_REG:  ld_byte = alias_q;
      RG_IO:   ld_byte = io_rdata;
      default: ld_byte = mem_rdata;
    endcase
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({io_re, mem_re})); // R5
  AST_STROBE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (io_re || mem_re) |-> (busy && !$past(busy))); // R5
  AST_MEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) mem_re |-> (mem_addr >= AW'(MEM_BASE))); // R5
  AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wb && lat_mode == AM_PLAIN) |-> $stable(ptr_cur)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(io_re || mem_re)); // R8
endmodule

// File: tb/ptrld_unit_tb.sv
module ptrld_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0; logic [1:0] ptr_sel = 0, mode = 0; logic [4:0] dst_idx = 0;
  logic busy, done;
  logic host_we = 0; logic [4:0] host_widx = 0, host_ridx = 0; logic [7:0] host_wdata = 0, host_rdata;
  logic io_re, mem_re; logic [5:0] io_addr; logic [15:0] mem_addr;
  logic [7:0] io_rdata = 0, mem_rdata = 0;

  int total = 0, bad = 0;
  logic [7:0] ref_rf [32];

  ptrld_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_sel(ptr_sel), .mode(mode), .dst_idx(dst_idx),
    .busy(busy), .done(done), .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
    .host_ridx(host_ridx), .host_rdata(host_rdata), .io_re(io_re), .io_addr(io_addr),
    .io_rdata(io_rdata), .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] io_fn(input logic [5:0] a);
    return {2'b10, a} ^ 8'h33;
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem_fn(mem_addr);
    if (io_re)  io_rdata  <= io_fn(io_addr);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_rf(input string tag);
    for (int i = 0; i < 32; i++) begin
      host_ridx = 5'(i); #1;
      chk(tag, {24'd0, host_rdata}, {24'd0, ref_rf[i]});
    end
  endtask

  task automatic host_wr(input int idx, input logic [7:0] val);
    @(negedge clk); host_we = 1; host_widx = 5'(idx); host_wdata = val;
    @(negedge clk); host_we = 0;
    ref_rf[idx] = val;
  endtask

  task automatic set_ptr(input int sel, input logic [15:0] p);
    host_wr(26 + 2*sel, p[7:0]);
    host_wr(27 + 2*sel, p[15:8]);
  endtask

  // Issues a load; poke=1 attempts a host write to register 5 during busy (R9).
  task automatic do_load(input int sel, input int md, input int dst, input bit poke);
    logic [15:0] p, ea, pn; logic [7:0] data; int lo;
    bit ok = (sel != 3) && (md != 3);
    @(negedge clk);
    start = 1; ptr_sel = 2'(sel); mode = 2'(md); dst_idx = 5'(dst);
    @(negedge clk); start = 0;
    if (!ok) begin
      chk("R8 busy on rejected", {31'd0, busy}, 0);
      chk("R8 strobes on rejected", {30'd0, io_re, mem_re}, 0);
      cmp_rf("R8 regs after rejected");
      return;
    end
    lo = 26 + 2*sel;
    p  = {ref_rf[lo+1], ref_rf[lo]};                           // R1
    ea = (md == 2) ? p - 16'd1 : p;                             // R2 R4
    pn = (md == 1) ? p + 16'd1 : (md == 2) ? p - 16'd1 : p;     // R3 R4
    if (ea < 16'h20)      data = ref_rf[ea[4:0]];
    else if (ea < 16'h60) data = io_fn(6'(ea - 16'h20));
    else                  data = mem_fn(ea);
    chk("R6 busy first cycle", {31'd0, busy}, 1);
    chk("R5 io_re", {31'd0, io_re}, {31'd0, (ea >= 16'h20 && ea < 16'h60)});
    chk("R5 mem_re", {31'd0, mem_re}, {31'd0, (ea >= 16'h60)});
    if (io_re)  chk("R5 io_addr", {26'd0, io_addr}, {26'd0, 6'(ea - 16'h20)});
    if (mem_re) chk("R5 mem_addr", {16'd0, mem_addr}, {16'd0, ea});
    if (poke) begin host_we = 1; host_widx = 5'd5; host_wdata = ~ref_rf[5]; end
    @(negedge clk);
    host_we = 0;
    chk("R6 busy second cycle", {31'd0, busy}, 1);
    chk("R6 done early", {31'd0, done}, 0);
    chk("R5 strobe late", {30'd0, io_re, mem_re}, 0);
    @(negedge clk);
    chk("R6 done", {31'd0, done}, 1);
    chk("R6 busy end", {31'd0, busy}, 0);
    if (md != 0) begin ref_rf[lo] = pn[7:0]; ref_rf[lo+1] = pn[15:8]; end
    ref_rf[dst] = data;                                          // R7
    host_ridx = 5'(dst); #1;
    chk("R6 dest at done", {24'd0, host_rdata}, {24'd0, data});
    cmp_rf("R1 R2 R3 R4 R7 R9 regs after load");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) ref_rf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 0);
    chk("R10 done", {31'd0, done}, 0);
    chk("R10 strobes", {30'd0, io_re, mem_re}, 0);
    cmp_rf("R10 regs");

    // Directed corner cases
    for (int i = 0; i < 26; i++) host_wr(i, 8'(8'h80 + i));
    set_ptr(0, 16'h0005); do_load(0, 0, 16, 0);       // R2 alias read
    set_ptr(1, 16'hFFFF); do_load(1, 1, 17, 0);       // R3 wrap
    set_ptr(2, 16'h0000); do_load(2, 2, 18, 0);       // R4 wrap
    set_ptr(0, 16'h0020); do_load(0, 0, 3, 0);        // R5 io low edge
    set_ptr(0, 16'h0060); do_load(0, 2, 4, 0);        // R5 io high edge 0x5F
    set_ptr(1, 16'h0060); do_load(1, 1, 6, 0);        // R5 mem low edge
    set_ptr(2, 16'h001E); do_load(2, 0, 30, 0);       // R7 alias own low byte
    set_ptr(0, 16'h12FF); do_load(0, 1, 26, 0);       // R7 dst = ptr low byte
    set_ptr(1, 16'h0100); do_load(1, 2, 29, 1);       // R7 dst = ptr high, R9 busy write
    do_load(3, 0, 7, 0);                               // R8 select 3
    do_load(0, 3, 7, 0);                               // R8 mode 3
    // R8: start held through a load is not re-accepted while busy
    set_ptr(2, 16'h4000);
    @(negedge clk); start = 1; ptr_sel = 2; mode = 0; dst_idx = 8;
    @(negedge clk); @(negedge clk); start = 0;
    @(negedge clk);
    chk("R8 done after held start", {31'd0, done}, 1);
    @(negedge clk);
    chk("R8 no second load", {31'd0, busy | done}, 0);
    ref_rf[8] = mem_fn(16'h4000);
    cmp_rf("R8 regs after held start");

    // Random loads with biased pointers
    for (int n = 0; n < 300; n++) begin
      int sel, md, dst, kind; logic [15:0] p;
      sel = $urandom % 3; md = $urandom % 3; dst = $urandom % 32; kind = $urandom % 4;
      case (kind)
        0: p = 16'($urandom % 33);
        1: p = 16'(16'h1F + $urandom % 66);
        2: p = 16'($urandom);
        default: p = ($urandom % 2) ? 16'hFFFF : 16'h0000;
      endcase
      if ($urandom % 3 == 0) set_ptr(sel, p);
      do_load(sel, md, dst, ($urandom % 5) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule